// File: doc/BRIEF.md
# Three-Source Sync Pulse Generator

This block makes the start strobe for a frame timing sequencer. Three sources can request a strobe, and each has its own enable. Any mix of the three may be enabled at the same time. The first source is an asynchronous pin, such as a once-per-second reference shared between separate units so that their frames line up. The second is a free-running counter that fires when it reaches a programmed compare value. The third is a software strobe that fires in the cycle it is written.

The pin is brought into the clock domain by a two-flop synchronizer, and only its low-to-high transition counts as a request. The counter is as wide as the compare value, which is 64 bits by default and is supplied as a low and a high 32-bit word. When the counter hits the compare value it wraps to zero, so it fires periodically. It stays cleared while its enable is low. The enabled requests are ORed together and registered. The output is never high for two cycles running.

Top module: `tsg_sync_gen`

## Requirements
- R1: During reset and in the first cycle after it, `sync_pulse` is low.
- R2: If `sw_trig` is high in a cycle while `en_sw` is high, `sync_pulse` is high in the next cycle, provided it was low in the cycle of the request.
- R3: A `sw_trig` strobe while `en_sw` is low produces no pulse.
- R4: A low-to-high transition on `ext_sync_in` that is sampled at a clock edge makes `sync_pulse` high in the cycle after the third clock edge from that sample. A pin held high produces only one pulse.
- R5: Transitions on `ext_sync_in` while `en_ext` is low produce no pulse. Setting `en_ext` while the pin is already high produces no pulse.
- R6: With `en_int` high and compare value M (M ≥ 1), the first internal pulse appears M+1 cycles after the first enabled cycle. Later pulses follow every M+1 cycles.
- R7: The compare value is the concatenation {`match_hi`, `match_lo`}. A nonzero high word keeps the counter from firing at the value of the low word alone.
- R8: Dropping `en_int` clears the counter. Re-enabling it restarts the phase, so the timing of R6 counts from the re-enable.
- R9: Requests from several sources in the same cycle give a single one-cycle pulse.
- R10: `sync_pulse` is never high in two consecutive cycles. A request in the cycle right after a pulse is absorbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_sync_in | input | 1 | Asynchronous external sync pin |
| en_ext | input | 1 | Enable for the external source |
| en_int | input | 1 | Enable for the internal counter source; low clears the counter |
| en_sw | input | 1 | Enable for the software source |
| sw_trig | input | 1 | Software trigger strobe |
| match_lo | input | 32 | Low word of the internal compare value |
| match_hi | input | 32 | High word of the internal compare value |
| sync_pulse | output | 1 | One-cycle sync strobe |

## Verification
Each source is tried alone, first with its enable set and then with it cleared. Comparing the two runs shows that the enable gates the source and the path is not simply always active. The pin is exercised with a held level, a fresh rise, and an enable raised while the pin is already high; together these show that the block responds to the transition and not to the level. The counter is run with a small compare value, with a nonzero high word, and with an interrupted enable, which checks the period, the use of the full width and the phase restart. Coincident requests and back-to-back requests check the merge and the one-cycle width.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    localparam int unsigned WORD_W = 32;

    typedef struct packed {
        logic ext;
        logic cnt;
        logic sw;
    } src_vec_t;

    function automatic logic any_enabled(src_vec_t req, src_vec_t en);
        src_vec_t g;
        g = req & en;
        return |g;
    endfunction

endpackage

// File: rtl/tsg_ext_edge.sv
module tsg_ext_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) shreg[i] <= 1'b0;
                    else     shreg[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) shreg[i] <= 1'b0;
                    else     shreg[i] <= shreg[i-1];
                end
            end
        end
    endgenerate

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/tsg_cnt_match.sv
module tsg_cnt_match #(
    parameter int unsigned CNT_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic [2*tsg_pkg::WORD_W-1:0] match_val,
    output logic                       hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;

    assign target = match_val[CNT_W-1:0];
    assign hit    = enable && (cnt_q == target);

    always_ff @(posedge clk) begin
        if (rst || !enable) cnt_q <= '0;
        else if (hit)       cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tsg_merge.sv
module tsg_merge (
    input  logic              clk,
    input  logic              rst,
    input  tsg_pkg::src_vec_t req,
    input  tsg_pkg::src_vec_t en,
    output logic              pulse
);
    logic any_req;

    assign any_req = tsg_pkg::any_enabled(req, en);

    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= any_req & ~pulse;
    end
endmodule

// File: rtl/tsg_sync_gen.sv
module tsg_sync_gen #(
    parameter int unsigned CNT_W       = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_sync_in,
    input  logic        en_ext,
    input  logic        en_int,
    input  logic        en_sw,
    input  logic        sw_trig,
    input  logic [31:0] match_lo,
    input  logic [31:0] match_hi,
    output logic        sync_pulse
);
    import tsg_pkg::*;

    src_vec_t req;
    src_vec_t en;
    logic     ext_rise;
    logic     cnt_hit;

    tsg_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_sync_in),
        .rise (ext_rise)
    );

    tsg_cnt_match #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (en_int),
        .match_val ({match_hi, match_lo}),
        .hit       (cnt_hit)
    );

    always_comb begin
        req.ext = ext_rise;
        req.cnt = cnt_hit;
        req.sw  = sw_trig;
        en.ext  = en_ext;
        en.cnt  = en_int;
        en.sw   = en_sw;
    end

    tsg_merge u_merge (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .en    (en),
        .pulse (sync_pulse)
    );
endmodule

// File: rtl/tsg_sync_gen_chk.sv
module tsg_sync_gen_chk (
    input logic clk,
    input logic rst,
    input logic en_ext,
    input logic en_int,
    input logic en_sw,
    input logic sw_trig,
    input logic sync_pulse
);
    AST_RESET_LOW: assert property (@(posedge clk) rst |=> !sync_pulse); // R1

    AST_SW_FIRES: assert property (@(posedge clk) disable iff (rst)
        (en_sw && sw_trig && !sync_pulse) |=> sync_pulse); // R2

    AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en_ext && !en_int && !en_sw) |=> !sync_pulse); // R3

    AST_EXT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (sync_pulse && !$past(en_sw && sw_trig) && !$past(en_int)) |-> $past(en_ext)); // R5

    AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse); // R10
endmodule

bind tsg_sync_gen tsg_sync_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_ext     (en_ext),
    .en_int     (en_int),
    .en_sw      (en_sw),
    .sw_trig    (sw_trig),
    .sync_pulse (sync_pulse)
);

// File: tb/tb_tsg_sync_gen.sv
`timescale 1ns/1ps
module tb_tsg_sync_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_sync_in = 1'b0;
    logic        en_ext = 1'b0;
    logic        en_int = 1'b0;
    logic        en_sw = 1'b0;
    logic        sw_trig = 1'b0;
    logic [31:0] match_lo = '0;
    logic [31:0] match_hi = '0;
    logic        sync_pulse;

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    vectors = 0;
    int    errors = 0;
    string cur_tag = "R1";

    tsg_sync_gen dut (
        .clk        (clk),
        .rst        (rst),
        .ext_sync_in(ext_sync_in),
        .en_ext     (en_ext),
        .en_int     (en_int),
        .en_sw      (en_sw),
        .sw_trig    (sw_trig),
        .match_lo   (match_lo),
        .match_hi   (match_hi),
        .sync_pulse (sync_pulse)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected pulse cycles
    always @(negedge clk) begin
        if (!rst) begin
            if (sync_pulse) begin
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected pulse at cycle %0d, expected none", cur_tag, cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    vectors++;
                    if (e.cyc != cyc) begin
                        errors++;
                        $display("FAIL %s: pulse at cycle %0d, expected cycle %0d", e.tag, cyc, e.cyc);
                    end
                end
            end else if (sb.size() != 0 && sb[0].cyc < cyc) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                errors++;
                $display("FAIL %s: no pulse at cycle %0d, expected 1 got 0", e.tag, e.cyc);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(int c, string t);
        exp_t e;
        e.cyc = c;
        e.tag = t;
        sb.push_back(e);
    endtask

    task automatic close_test(string t);
        step(3);
        vectors++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected pulses outstanding, expected 0", t, sb.size());
            sb.delete();
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        vectors++;
        if (sync_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: sync_pulse=%b during reset, expected 0", sync_pulse);
        end
        step(1);
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (sync_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: sync_pulse=%b after reset, expected 0", sync_pulse);
        end
        step(2);

        // R2: software trigger
        cur_tag = "R2";
        en_sw = 1'b1;
        sw_trig = 1'b1; push(cyc + 1, "R2");
        step(1); sw_trig = 1'b0;
        step(4);
        sw_trig = 1'b1; push(cyc + 1, "R2");
        step(1); sw_trig = 1'b0;
        close_test("R2");

        // R10: back-to-back requests absorbed
        cur_tag = "R10";
        sw_trig = 1'b1; push(cyc + 1, "R10");
        step(2); sw_trig = 1'b0;
        close_test("R10");
        en_sw = 1'b0;

        // R3: software disabled
        cur_tag = "R3";
        sw_trig = 1'b1; step(2); sw_trig = 1'b0;
        close_test("R3");

        // R4: external rising edge, held level
        cur_tag = "R4";
        en_ext = 1'b1;
        ext_sync_in = 1'b1; push(cyc + 3, "R4");
        step(10);
        ext_sync_in = 1'b0; step(4);
        ext_sync_in = 1'b1; push(cyc + 3, "R4");
        step(6);
        ext_sync_in = 1'b0;
        close_test("R4");

        // R5: external disabled, and enable while pin high
        cur_tag = "R5";
        en_ext = 1'b0;
        ext_sync_in = 1'b1; step(6);
        en_ext = 1'b1; step(8);
        close_test("R5");
        ext_sync_in = 1'b0; step(4);
        ext_sync_in = 1'b1; push(cyc + 3, "R5");
        step(5);
        ext_sync_in = 1'b0; en_ext = 1'b0;
        close_test("R5");

        // R6: internal counter, M = 5, period 6
        cur_tag = "R6";
        match_lo = 32'd5; match_hi = 32'd0;
        begin
            int n;
            n = cyc;
            en_int = 1'b1;
            push(n + 6, "R6"); push(n + 12, "R6"); push(n + 18, "R6");
            step(20);
            en_int = 1'b0;
        end
        close_test("R6");

        // R7: high word participates in the compare
        cur_tag = "R7";
        match_lo = 32'd3; match_hi = 32'd1;
        en_int = 1'b1; step(25);
        en_int = 1'b0;
        close_test("R7");

        // R8: disable clears the counter
        cur_tag = "R8";
        match_lo = 32'd5; match_hi = 32'd0;
        en_int = 1'b1; step(3);
        en_int = 1'b0; step(2);
        begin
            int n;
            n = cyc;
            en_int = 1'b1;
            push(n + 6, "R8");
            step(8);
            en_int = 1'b0;
        end
        close_test("R8");

        // R9: coincident internal and software requests
        cur_tag = "R9";
        en_sw = 1'b1;
        begin
            int n;
            n = cyc;
            en_int = 1'b1;
            push(n + 6, "R9");
            step(5);
            sw_trig = 1'b1;
            step(1);
            sw_trig = 1'b0;
            step(2);
            en_int = 1'b0;
        end
        en_sw = 1'b0;
        close_test("R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule